// File: doc/BRIEF.md
# Inter-processor message queue hub

This block keeps a small set of hardware message queues that let two processors exchange fixed-size messages. Each message is sixteen 32-bit words. A host processor reaches the queues through a simple word-wide register bus with byte strobes. The far side reaches them through two message-wide streams. Each queue has a fixed direction, set by the `TX_MASK` parameter. In a transmit queue the host assembles a message word by word. Writing the final data word commits the whole message in one step, and the message later leaves on the egress stream. In a receive queue the far side pushes whole messages in through the ingress stream. The host reads the head message word by word, and reading the final word removes it from the queue.

The host window for a queue is 32 word registers at byte address `{qid, widx, 2'b00}`:

| Index | Contents |
|---|---|
| 0 | Message count |
| 1 | Bit 0: sticky overflow flag |
| 2 | Bit 0: sticky, block-wide access-error flag |
| 16..31 | Data words 0..15 |

Only full-word accesses take effect. Each receive queue drives an interrupt line that stays high while the queue holds anything.

Both streams use valid/ready. The sender holds valid, qid and data stable until ready is seen high at a clock edge, and the transfer happens on that edge. The egress side never withdraws or changes a message it has offered. The ingress side lowers ready when the addressed receive queue is full.

Top module: `msgq_hub`

## Requirements
- R1: Host writes of data indices 16..31 to a transmit queue fill a staging message. The write to index 31 commits all sixteen words as one message, and that queue's count rises by one. The message leaves on egress with data word j in bits [32j+31:32j].
- R2: `eg_valid` is high whenever any transmit queue holds a message. When the egress is free, the lowest-numbered non-empty transmit queue is chosen. While `eg_valid` is high and `eg_ready` is low, `eg_qid` and `eg_data` hold. A handshake pops that message.
- R3: A message offered on ingress to a receive queue is appended when `ig_ready` is high. `ig_ready` is low while that queue holds DEPTH messages. A message offered to a transmit queue index is accepted and discarded.
- R4: A host read of data index 16+k of a receive queue returns word k of the head message, one cycle later, with `bus_rvalid`. A read of index 31 pops the head. A read of an empty queue returns zero and the count stays zero.
- R5: Index 0 reads the number of messages the queue holds, from 0 to DEPTH.
- R6: An access with `bus_be` not equal to 4'hF has no effect on any queue: a write stores nothing and a read returns zero and pops nothing. It sets the access-error flag (index 2, bit 0).
- R7: Data words not written since the last commit are stored as zero. Words may skip forward. A write to an index below the next expected word is ignored and sets the access-error flag. A commit clears the staging message.
- R8: A commit to a transmit queue that holds DEPTH messages is dropped. The count is unchanged and the queue's overflow flag (index 1, bit 0) is set and stays set.
- R9: `irq[i]` is high exactly while receive queue i is non-empty. Transmit queues never raise it.
- R10: A host write to the data window of a receive queue is ignored and sets the access-error flag. Reads of a transmit queue's data window return zero.
- R11: Reset empties all queues, clears staging and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | log2(NUM_Q)+7 | Byte address {qid, widx, 2'b00} |
| bus_be | input | 4 | Byte strobes; only 4'hF takes effect |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| eg_valid | output | 1 | Egress message offered |
| eg_ready | input | 1 | Egress message taken |
| eg_qid | output | log2(NUM_Q) | Source queue of the egress message |
| eg_data | output | 512 | Egress message, word j at bits [32j+31:32j] |
| ig_valid | input | 1 | Ingress message offered |
| ig_ready | output | 1 | Ingress message accepted |
| ig_qid | input | log2(NUM_Q) | Target queue of the ingress message |
| ig_data | input | 512 | Ingress message, same word order |
| irq | output | NUM_Q | Per-queue not-empty interrupt, receive queues only |

## Verification
The bench builds the hub with four queues, a depth of two and `TX_MASK` = 4'b0101, so queues 0 and 2 transmit and queues 1 and 3 receive. With a depth of two, the third commit or the third ingress message already reaches a full queue. That makes overflow and back-pressure cheap to hit. Two transmit queues are enough to show that the lowest index wins and that a message already on offer is held while a lower queue fills. Random traffic across all four queues then mixes skipped, backward and partial writes with pops from both sides.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 16;
  localparam int MSG_W     = WORD_W * MSG_WORDS;
  localparam int WIN_LG    = 7;  // 32 word registers per queue window

  localparam logic [4:0] REG_COUNT  = 5'd0;
  localparam logic [4:0] REG_STATUS = 5'd1;
  localparam logic [4:0] REG_ERROR  = 5'd2;
  localparam logic [4:0] REG_LAST   = 5'd31;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [MSG_W-1:0]  msg_t;
endpackage

// File: rtl/msgq_fifo.sv
module msgq_fifo
  import msgq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  msg_t             push_msg,
  input  logic             pop,
  output msg_t             head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  msg_t mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_msg;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count))); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R4
endmodule

// File: rtl/msgq_stage.sv
module msgq_stage
  import msgq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_idx,
  input  word_t      wr_data,
  output logic       reject,
  output logic       commit,
  output msg_t       msg
);
  msg_t       buf_q;
  logic [3:0] nxt;
  logic       accept;

  assign accept = wr_en & (wr_idx >= nxt);
  assign reject = wr_en & ~accept;
  assign commit = accept & (wr_idx == 4'(MSG_WORDS - 1));

  always_comb begin
    msg = buf_q;
    msg[32*wr_idx +: 32] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      nxt   <= '0;
    end else if (commit) begin
      buf_q <= '0;
      nxt   <= '0;
    end else if (accept) begin
      buf_q[32*wr_idx +: 32] <= wr_data;
      nxt <= wr_idx + 4'd1;
    end
  end

  AST_BACKWARD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(nxt) && $stable(buf_q))); // R7
endmodule

// File: rtl/msgq_pick.sv
module msgq_pick #(
  parameter int NUM_Q = 4,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] req,
  input  logic             ready,
  output logic             valid,
  output logic [QW-1:0]    idx
);
  logic          held;
  logic [QW-1:0] hidx, pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_Q - 1; i >= 0; i--) begin
      if (req[i]) pick = QW'(i);
    end
  end

  assign valid = held | (|req);
  assign idx   = held ? hidx : pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      hidx <= '0;
    end else if (valid && !ready) begin
      held <= 1'b1;
      hidx <= idx;
    end else if (valid && ready) begin
      held <= 1'b0;
    end
  end

  AST_EG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && idx == $past(idx))); // R2
endmodule

// File: rtl/msgq_hub.sv
module msgq_hub
  import msgq_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 4,
  parameter logic [NUM_Q-1:0] TX_MASK = {(NUM_Q/2){2'b01}},
  localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int AW    = QW + WIN_LG,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic             bus_rvalid,
  output logic [31:0]      bus_rdata,
  output logic             eg_valid,
  input  logic             eg_ready,
  output logic [QW-1:0]    eg_qid,
  output logic [MSG_W-1:0] eg_data,
  input  logic             ig_valid,
  output logic             ig_ready,
  input  logic [QW-1:0]    ig_qid,
  input  logic [MSG_W-1:0] ig_data,
  output logic [NUM_Q-1:0] irq
);
  logic [QW-1:0] qsel;
  logic [4:0]    widx;
  logic [3:0]    kword;
  logic full_be, acc_ok, is_data, sel_tx, rd_pop;

  assign qsel    = bus_addr[AW-1:WIN_LG];
  assign widx    = bus_addr[WIN_LG-1:2];
  assign kword   = widx[3:0];
  assign is_data = widx[4];
  assign full_be = &bus_be;
  assign acc_ok  = bus_req & full_be;
  assign sel_tx  = TX_MASK[qsel];

  logic [NUM_Q-1:0] push, pop, full, empty, st_reject, st_commit, ovf;
  msg_t             st_msg   [NUM_Q];
  msg_t             push_msg [NUM_Q];
  msg_t             head     [NUM_Q];
  logic [CNT_W-1:0] cnt      [NUM_Q];
  logic             acc_err;

  assign rd_pop = acc_ok & ~bus_we & (widx == REG_LAST) & ~sel_tx;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    if (TX_MASK[i]) begin : g_tx
      msgq_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_ok & bus_we & is_data & (qsel == QW'(i))),
        .wr_idx  (kword),
        .wr_data (bus_wdata),
        .reject  (st_reject[i]),
        .commit  (st_commit[i]),
        .msg     (st_msg[i])
      );
      assign push[i]     = st_commit[i];
      assign push_msg[i] = st_msg[i];
      assign pop[i]      = eg_valid & eg_ready & (eg_qid == QW'(i));
    end else begin : g_rx
      assign st_reject[i] = 1'b0;
      assign st_commit[i] = 1'b0;
      assign st_msg[i]    = '0;
      assign push[i]      = ig_valid & ig_ready & (ig_qid == QW'(i));
      assign push_msg[i]  = ig_data;
      assign pop[i]       = rd_pop & (qsel == QW'(i));
    end

    msgq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push[i]),
      .push_msg (push_msg[i]),
      .pop      (pop[i]),
      .head     (head[i]),
      .count    (cnt[i]),
      .full     (full[i]),
      .empty    (empty[i])
    );

    assign irq[i] = ~TX_MASK[i] & ~empty[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ovf[i] <= 1'b0;
      else if (st_commit[i] & full[i]) ovf[i] <= 1'b1;
    end
  end

  // Egress: fixed priority with a hold once a message is on offer
  msgq_pick #(.NUM_Q(NUM_Q)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (TX_MASK & ~empty),
    .ready (eg_ready),
    .valid (eg_valid),
    .idx   (eg_qid)
  );
  assign eg_data = head[eg_qid];

  // Ingress: back-pressure only from a full receive queue
  assign ig_ready = TX_MASK[ig_qid] ? 1'b1 : ~full[ig_qid];

  // Sticky access-error flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else if (bus_req & (~full_be | (bus_we & is_data & (~sel_tx | (|st_reject)))))
      acc_err <= 1'b1;
  end

  // Host read path
  word_t rd_word;
  always_comb begin
    rd_word = '0;
    if (full_be) begin
      if (widx == REG_COUNT)        rd_word = 32'(cnt[qsel]);
      else if (widx == REG_STATUS)  rd_word = {31'b0, ovf[qsel]};
      else if (widx == REG_ERROR)   rd_word = {31'b0, acc_err};
      else if (is_data && !sel_tx)  rd_word = head[qsel][32*kword +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_req & ~bus_we;
      bus_rdata  <= (bus_req & ~bus_we) ? rd_word : '0;
    end
  end

  AST_EG_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_valid && !eg_ready) |=> $stable(eg_data)); // R2
  AST_PARTIAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(&bus_be)) |=> acc_err); // R6
endmodule

// File: tb/msgq_hub_tb.sv
module msgq_hub_tb;
  localparam int CLK_P = 10;
  localparam int NQ = 4;
  localparam int DP = 2;
  localparam logic [NQ-1:0] TXM = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic eg_valid, eg_ready = 1'b0;
  logic [1:0] eg_qid;
  logic [511:0] eg_data;
  logic ig_valid = 1'b0, ig_ready;
  logic [1:0] ig_qid = '0;
  logic [511:0] ig_data = '0;
  logic [NQ-1:0] irq;

  always #(CLK_P/2) clk = ~clk;

  msgq_hub #(.NUM_Q(NQ), .DEPTH(DP), .TX_MASK(TXM)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_qid(eg_qid), .eg_data(eg_data),
    .ig_valid(ig_valid), .ig_ready(ig_ready), .ig_qid(ig_qid), .ig_data(ig_data),
    .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [511:0] mq [NQ][DP];
  int mhead [NQ], mcnt [NQ], mnxt [NQ];
  logic [511:0] mstg [NQ];
  bit movf [NQ];
  bit merr;
  int mlock;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit is_tx(int q); return TXM[q]; endfunction
  function automatic logic [8:0] adr(int q, int w); return 9'(q*128 + w*4); endfunction

  function automatic logic [511:0] rnd_msg();
    logic [511:0] m;
    for (int w = 0; w < 16; w++) m[32*w +: 32] = $urandom;
    return m;
  endfunction

  task automatic upd_lock();
    if (mlock < 0)
      for (int q = 0; q < NQ; q++)
        if (mlock < 0 && is_tx(q) && mcnt[q] > 0) mlock = q;
  endtask

  task automatic mpush(int q, logic [511:0] m);
    mq[q][(mhead[q] + mcnt[q]) % DP] = m;
    mcnt[q]++;
    upd_lock();
  endtask

  task automatic mpop(int q);
    mhead[q] = (mhead[q] + 1) % DP;
    mcnt[q]--;
  endtask

  task automatic bus_wr(int q, int w, logic [31:0] d, logic [3:0] be);
    int k;
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = adr(q, w); bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_be = 0;
    if (be != 4'hF) merr = 1;
    else if (w >= 16) begin
      k = w - 16;
      if (!is_tx(q) || k < mnxt[q]) merr = 1;
      else begin
        mstg[q][32*k +: 32] = d;
        mnxt[q] = k + 1;
        if (k == 15) begin
          if (mcnt[q] < DP) mpush(q, mstg[q]);
          else movf[q] = 1;
          mstg[q] = '0;
          mnxt[q] = 0;
        end
      end
    end
  endtask

  task automatic write_msg(int q, logic [511:0] m);
    for (int w = 0; w < 16; w++) bus_wr(q, 16 + w, m[32*w +: 32], 4'hF);
  endtask

  task automatic bus_rd(int q, int w, logic [3:0] be, string r);
    logic [31:0] exp;
    exp = '0;
    if (be == 4'hF) begin
      if (w == 0) exp = 32'(mcnt[q]);
      else if (w == 1) exp = {31'b0, movf[q]};
      else if (w == 2) exp = {31'b0, merr};
      else if (w >= 16 && !is_tx(q) && mcnt[q] > 0) exp = mq[q][mhead[q]][32*(w-16) +: 32];
    end
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = adr(q, w); bus_be = be;
    @(negedge clk);
    bus_req = 0; bus_be = 0;
    chk({r, " rvalid"}, {31'b0, bus_rvalid}, 32'd1);
    chk({r, " rdata"}, bus_rdata, exp);
    if (be != 4'hF) merr = 1;
    else if (w == 31 && !is_tx(q) && mcnt[q] > 0) mpop(q);
  endtask

  task automatic take(string r);
    @(negedge clk);
    chk({r, " eg_valid"}, {31'b0, eg_valid}, {31'b0, mlock >= 0});
    if (mlock >= 0) begin
      chk({r, " eg_qid"}, {30'b0, eg_qid}, 32'(mlock));
      for (int w = 0; w < 16; w++)
        chk({r, " eg_data"}, eg_data[32*w +: 32], mq[mlock][mhead[mlock]][32*w +: 32]);
      eg_ready = 1;
      @(negedge clk);
      eg_ready = 0;
      mpop(mlock);
      mlock = -1;
      upd_lock();
    end
  endtask

  task automatic ingress(int q, logic [511:0] m, string r);
    bit exp;
    exp = is_tx(q) ? 1'b1 : (mcnt[q] < DP);
    @(negedge clk);
    ig_valid = 1; ig_qid = 2'(q); ig_data = m;
    #1;
    chk({r, " ig_ready"}, {31'b0, ig_ready}, {31'b0, exp});
    @(negedge clk);
    ig_valid = 0;
    if (exp && !is_tx(q)) mpush(q, m);
  endtask

  task automatic chk_irq(string r);
    logic [NQ-1:0] e;
    for (int q = 0; q < NQ; q++) e[q] = !is_tx(q) && mcnt[q] > 0;
    @(negedge clk);
    chk(r, 32'(irq), 32'(e));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] m1, m2, m3;
    int op, q, w;
    void'($urandom(32'd5150));
    for (int i = 0; i < NQ; i++) begin
      mhead[i] = 0; mcnt[i] = 0; mnxt[i] = 0; mstg[i] = '0; movf[i] = 0;
    end
    merr = 0; mlock = -1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state
    @(negedge clk);
    chk("R11 eg_valid", {31'b0, eg_valid}, 32'd0);
    chk("R11 irq", 32'(irq), 32'd0);
    for (int i = 0; i < NQ; i++) bus_rd(i, 0, 4'hF, "R11 count");
    bus_rd(0, 1, 4'hF, "R11 ovf");
    bus_rd(0, 2, 4'hF, "R11 err");

    // R1: full message, R5 count
    m1 = rnd_msg();
    write_msg(0, m1);
    bus_rd(0, 0, 4'hF, "R5 count one");
    take("R1 egress");
    // R7: skipped words read as zero
    bus_wr(2, 19, 32'hA5A5_0003, 4'hF);
    bus_wr(2, 31, 32'hA5A5_000F, 4'hF);
    take("R7 skipped zero");
    // R2: q2 on offer and held while q0 fills
    write_msg(2, rnd_msg());
    write_msg(0, rnd_msg());
    take("R2 held q2");
    take("R2 then q0");
    write_msg(0, rnd_msg());
    write_msg(2, rnd_msg());
    take("R2 lowest first");
    take("R2 second");
    bus_rd(0, 2, 4'hF, "R11 err still clear");
    // R7: backward write ignored
    bus_wr(0, 21, 32'h0000_0505, 4'hF);
    bus_wr(0, 18, 32'hDEAD_0002, 4'hF);
    bus_wr(0, 31, 32'h0000_0F0F, 4'hF);
    take("R7 backward ignored");
    bus_rd(0, 2, 4'hF, "R7 err set");
    // R8: overflow
    write_msg(0, rnd_msg());
    write_msg(0, rnd_msg());
    write_msg(0, rnd_msg());
    bus_rd(0, 0, 4'hF, "R8 count held");
    bus_rd(0, 1, 4'hF, "R8 ovf");
    take("R8 drain a");
    take("R8 drain b");
    take("R8 drained");
    // R3, R4, R9
    m1 = rnd_msg(); m2 = rnd_msg(); m3 = rnd_msg();
    ingress(1, m1, "R3 first");
    ingress(1, m2, "R3 second");
    ingress(1, m3, "R3 full");
    chk_irq("R9 irq q1");
    ingress(0, m3, "R3 tx dropped");
    bus_rd(0, 0, 4'hF, "R3 tx count");
    take("R3 no egress");
    bus_rd(1, 16, 4'hF, "R4 word0");
    bus_rd(1, 20, 4'hF, "R4 word4");
    bus_rd(1, 31, 4'hF, "R4 pop");
    bus_rd(1, 0, 4'hF, "R5 count after pop");
    bus_rd(1, 31, 4'hF, "R4 pop2");
    chk_irq("R9 irq clear");
    bus_rd(3, 31, 4'hF, "R4 empty read");
    bus_rd(3, 0, 4'hF, "R4 empty count");
    // R6: partial strobes
    for (int w2 = 16; w2 < 32; w2++) bus_wr(2, w2, 32'(w2), (w2 == 31) ? 4'h7 : 4'hF);
    bus_rd(2, 0, 4'hF, "R6 partial commit");
    bus_wr(2, 31, 32'h1, 4'hF);
    take("R6 stage kept");
    ingress(1, m3, "R6 fill");
    bus_rd(1, 31, 4'hC, "R6 partial read");
    bus_rd(1, 0, 4'hF, "R6 no pop");
    bus_rd(1, 31, 4'hF, "R6 full pop");
    // R10: direction
    bus_wr(1, 31, 32'h1234, 4'hF);
    bus_rd(1, 0, 4'hF, "R10 rx write ignored");
    write_msg(0, rnd_msg());
    bus_rd(0, 16, 4'hF, "R10 tx read zero");
    take("R10 tx drain");

    // Random traffic
    for (int it = 0; it < 600; it++) begin
      op = $urandom_range(0, 7);
      case (op)
        0, 1: begin
          q = ($urandom_range(0, 1) == 0) ? 0 : 2;
          w = 16 + $urandom_range(0, 15);
          bus_wr(q, w, $urandom, ($urandom_range(0, 7) == 0) ? 4'h3 : 4'hF);
        end
        2: bus_wr($urandom_range(0, 3), 31, $urandom, 4'hF);
        3: take("R2 random egress");
        4: ingress($urandom_range(0, 3), rnd_msg(), "R3 random ingress");
        5: bus_rd($urandom_range(0, 3), 16 + $urandom_range(0, 15),
                  ($urandom_range(0, 7) == 0) ? 4'h1 : 4'hF, "R4 random read");
        6: bus_rd($urandom_range(0, 3), $urandom_range(0, 2), 4'hF, "R5 random reg");
        default: chk_irq("R9 random irq");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule